// File: doc/BRIEF.md
# TCP Offload Stream Bridge Controller

This block joins a TCP offload engine to a 64-bit streaming core. After reset it configures the engine by issuing eleven register writes from a fixed script. The script runs from step 11 down to step 1. The writes go out on a narrow port with a 4-bit address and 32-bit data. The block then waits for the engine's busy flag to drop. From that point on it moves traffic in both directions.

On the receive side, the engine's receive buffer reports a 13-bit word count. Whenever that count is nonzero and the bridge is idle, the bridge captures the count and reads exactly that many words. Read data arrives one cycle after the read strobe, so the bridge delivers each word to the core on `dataIn` with `dataInValid` asserted one cycle after the read.

On the transmit side, processed words from the core go straight into the engine's transmit buffer while a counter tallies them. A falling edge on `dataOutValid` marks the end of a burst. Once the engine is not busy, the bridge writes the burst's word count to the length register. On the next cycle it writes zero to the command register to start the send.

Top module: `tcp_stream_bridge`

## Requirements
- R1: While `rstN` is low, `regWrEn`, `rxRdEn`, `dataInValid` and `txWrEn` are all 0.
- R2: After reset release, exactly eleven register writes appear on consecutive cycles, in this order of (address, data): (0x0, 0x1), (0xE, 0x0), (0xC, 0x0), (0x9, 0x6000), (0x7, 0xEA60), (0x6, 0xEA61), (0x5, 0xC0A80750), (0x4, 0xC0A80751), (0x3, 0x1122), (0x2, 0x33445566), (0x0, 0x0).
- R3: `rxRdEn` is never asserted before all eleven setup writes have been issued and `engBusy` has been seen at 0.
- R4: When the bridge is idle and `rxCount` is N (N > 0), it reads exactly N words, with no read from an empty buffer and no word left behind.
- R5: `dataInValid` equals `rxRdEn` delayed by one cycle. While it is high, `dataIn` carries the word returned by the engine, in buffer order.
- R6: In the same cycle, `txWrEn` equals `dataOutValid`, and `txWrData` equals `dataOut` whenever `txWrEn` is high.
- R7: After `dataOutValid` falls from 1 to 0, the bridge writes the burst's word count to address 0x1 (length register). On the very next cycle it writes 0x00000000 to address 0x8 (command register).
- R8: The length write is issued only from a cycle in which `engBusy` is 0. While `engBusy` stays high, the length write is held back.
- R9: The word counter restarts at the length write, and a word accepted in that same cycle counts toward the next burst. As a result, back-to-back bursts separated by one idle cycle each report their own length.
- R10: No receive read burst starts while a transmit commit is pending, that is, from a falling edge of `dataOutValid` until the length write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| engBusy | input | 1 | Engine busy flag |
| regAddr | output | 4 | Engine register write address |
| regWrData | output | 32 | Engine register write data |
| regWrEn | output | 1 | One-cycle register write strobe |
| rxCount | input | 13 | Words waiting in the engine receive buffer |
| rxRdEn | output | 1 | Receive buffer read strobe |
| rxRdData | input | 64 | Receive buffer data, valid one cycle after the read strobe |
| dataInValid | output | 1 | Word valid toward the processing core |
| dataIn | output | 64 | Word toward the processing core |
| dataOutValid | input | 1 | Processed word valid from the core |
| dataOut | input | 64 | Processed word from the core |
| txWrEn | output | 1 | Transmit buffer write strobe |
| txWrData | output | 64 | Transmit buffer write data |

## Verification
A wrong sequence step shows up at once as a mismatched address or data value within the first eleven cycles after reset. A wrong drain counter shows up as an extra read against an empty buffer, or as words stuck in the buffer. A lost commit flag appears as a length write that never comes, or that comes with the wrong count. A missing pending guard lets a receive burst start while a commit is outstanding, which is visible on `rxRdEn` one cycle after the falling edge. The reference model checks data, strobes and register traffic on every cycle, so most faults are reported on the cycle they first reach a port.

// File: rtl/tcp_bridge_pkg.sv
`timescale 1ns/1ps
package tcp_bridge_pkg;
  localparam int REG_ADDR_W = 4;
  localparam int REG_DATA_W = 32;
  localparam int STEP_W = 4;
  localparam logic [STEP_W-1:0] FIRST_STEP = 4'hB;
  localparam logic [REG_ADDR_W-1:0] DEF_LEN_ADDR = 4'h1;
  localparam logic [REG_ADDR_W-1:0] DEF_CMD_ADDR = 4'h8;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_WAIT_READY,
    ST_IDLE,
    ST_DRAIN,
    ST_CMD
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              initWr;
    logic [STEP_W-1:0] step;
    logic              lenWr;
    logic              cmdWr;
    logic              rxRd;
  } bridgeStrobe_t;

  function automatic logic [REG_ADDR_W-1:0] initAddr(input logic [STEP_W-1:0] s);
    case (s)
      4'hB: initAddr = 4'h0;
      4'hA: initAddr = 4'hE;
      4'h9: initAddr = 4'hC;
      4'h8: initAddr = 4'h9;
      4'h7: initAddr = 4'h7;
      4'h6: initAddr = 4'h6;
      4'h5: initAddr = 4'h5;
      4'h4: initAddr = 4'h4;
      4'h3: initAddr = 4'h3;
      4'h2: initAddr = 4'h2;
      default: initAddr = 4'h0;
    endcase
  endfunction

  function automatic logic [REG_DATA_W-1:0] initData(input logic [STEP_W-1:0] s);
    case (s)
      4'hB: initData = 32'h0000_0001;
      4'h8: initData = 32'h0000_6000;
      4'h7: initData = 32'h0000_EA60;
      4'h6: initData = 32'h0000_EA61;
      4'h5: initData = 32'hC0A8_0750;
      4'h4: initData = 32'hC0A8_0751;
      4'h3: initData = 32'h0000_1122;
      4'h2: initData = 32'h3344_5566;
      default: initData = 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/bridge_ctrl.sv
`timescale 1ns/1ps
module bridge_ctrl
  import tcp_bridge_pkg::*;
#(
  parameter int RX_CNT_W = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                engBusy,
  input  logic [RX_CNT_W-1:0] rxCount,
  input  logic                txFall,
  output bridgeStrobe_t       strobe
);
  bridgeState_t        state;
  logic [STEP_W-1:0]   step;
  logic [RX_CNT_W-1:0] remain;
  logic                commitPend;
  logic                startLen;
  logic                startDrain;

  always_comb begin
    startLen   = (state == ST_IDLE) && commitPend && !engBusy;
    startDrain = (state == ST_IDLE) && !commitPend && !txFall && (rxCount != '0);
    strobe.initWr = (state == ST_INIT);
    strobe.step   = step;
    strobe.lenWr  = startLen;
    strobe.cmdWr  = (state == ST_CMD);
    strobe.rxRd   = (state == ST_DRAIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_INIT;
      step   <= FIRST_STEP;
      remain <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          step <= step - 1'b1;
          if (step == 4'h1) state <= ST_WAIT_READY;
        end
        ST_WAIT_READY: if (!engBusy) state <= ST_IDLE;
        ST_IDLE: begin
          if (startLen) begin
            state <= ST_CMD;
          end else if (startDrain) begin
            remain <= rxCount;
            state  <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          remain <= remain - 1'b1;
          if (remain == {{(RX_CNT_W-1){1'b0}}, 1'b1}) state <= ST_IDLE;
        end
        ST_CMD:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // commit request: a falling edge wins over the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          commitPend <= 1'b0;
    else if (txFall)    commitPend <= 1'b1;
    else if (startLen)  commitPend <= 1'b0;
  end
endmodule

// File: rtl/bridge_datapath.sv
`timescale 1ns/1ps
module bridge_datapath
  import tcp_bridge_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TX_CNT_W = 16,
  parameter logic [REG_ADDR_W-1:0] LEN_ADDR = DEF_LEN_ADDR,
  parameter logic [REG_ADDR_W-1:0] CMD_ADDR = DEF_CMD_ADDR
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bridgeStrobe_t         strobe,
  input  logic [DATA_W-1:0]     rxRdData,
  input  logic                  dataOutValid,
  input  logic [DATA_W-1:0]     dataOut,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [REG_DATA_W-1:0] regWrData,
  output logic                  regWrEn,
  output logic                  dataInValid,
  output logic [DATA_W-1:0]     dataIn,
  output logic                  txWrEn,
  output logic [DATA_W-1:0]     txWrData,
  output logic                  txFall
);
  logic                validPrev;
  logic [TX_CNT_W-1:0] txCount;

  assign dataIn   = rxRdData;
  assign txWrEn   = dataOutValid;
  assign txWrData = dataOut;
  assign txFall   = validPrev && !dataOutValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataInValid <= 1'b0;
      validPrev   <= 1'b0;
    end else begin
      dataInValid <= strobe.rxRd;
      validPrev   <= dataOutValid;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txCount <= '0;
    else if (strobe.lenWr)  txCount <= {{(TX_CNT_W-1){1'b0}}, dataOutValid};
    else if (dataOutValid)  txCount <= txCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regAddr   <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= strobe.initWr || strobe.lenWr || strobe.cmdWr;
      if (strobe.initWr) begin
        regAddr   <= initAddr(strobe.step);
        regWrData <= initData(strobe.step);
      end else if (strobe.lenWr) begin
        regAddr   <= LEN_ADDR;
        regWrData <= REG_DATA_W'(txCount);
      end else if (strobe.cmdWr) begin
        regAddr   <= CMD_ADDR;
        regWrData <= '0;
      end else begin
        regAddr   <= '0;
        regWrData <= '0;
      end
    end
  end
endmodule

// File: rtl/tcp_stream_bridge.sv
`timescale 1ns/1ps
module tcp_stream_bridge
  import tcp_bridge_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int RX_CNT_W = 13,
  parameter int TX_CNT_W = 16,
  parameter logic [REG_ADDR_W-1:0] LEN_ADDR = DEF_LEN_ADDR,
  parameter logic [REG_ADDR_W-1:0] CMD_ADDR = DEF_CMD_ADDR
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  engBusy,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [REG_DATA_W-1:0] regWrData,
  output logic                  regWrEn,
  input  logic [RX_CNT_W-1:0]   rxCount,
  output logic                  rxRdEn,
  input  logic [DATA_W-1:0]     rxRdData,
  output logic                  dataInValid,
  output logic [DATA_W-1:0]     dataIn,
  input  logic                  dataOutValid,
  input  logic [DATA_W-1:0]     dataOut,
  output logic                  txWrEn,
  output logic [DATA_W-1:0]     txWrData
);
  bridgeStrobe_t strobe;
  logic          txFall;

  bridge_ctrl #(.RX_CNT_W(RX_CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .engBusy(engBusy), .rxCount(rxCount),
    .txFall(txFall), .strobe(strobe)
  );

  bridge_datapath #(
    .DATA_W(DATA_W), .TX_CNT_W(TX_CNT_W), .LEN_ADDR(LEN_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxRdData(rxRdData),
    .dataOutValid(dataOutValid), .dataOut(dataOut), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .dataInValid(dataInValid),
    .dataIn(dataIn), .txWrEn(txWrEn), .txWrData(txWrData), .txFall(txFall)
  );

  assign rxRdEn = strobe.rxRd;
endmodule

// File: rtl/bridge_checker.sv
`timescale 1ns/1ps
module bridge_checker
  import tcp_bridge_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  engBusy,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [REG_DATA_W-1:0] regWrData,
  input logic                  regWrEn,
  input logic                  rxRdEn,
  input logic                  dataInValid
);
  logic [3:0] setupSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              setupSeen <= '0;
    else if (regWrEn && setupSeen != 4'd11) setupSeen <= setupSeen + 1'b1;
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rstN)
    dataInValid == $past(rxRdEn)); // R5
  AST_RX_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    rxRdEn |-> setupSeen == 4'd11); // R3
  AST_LEN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == DEF_LEN_ADDR) |-> $past(!engBusy)); // R8
  AST_CMD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == DEF_LEN_ADDR) |=> (regWrEn && regAddr == DEF_CMD_ADDR && regWrData == '0)); // R7
  AST_CMD_HAS_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == DEF_CMD_ADDR) |-> $past(regWrEn && regAddr == DEF_LEN_ADDR)); // R7
  AST_RX_QUIET_REG: assert property (@(posedge clk) disable iff (!rstN)
    rxRdEn |-> !regWrEn); // R10
endmodule

bind tcp_stream_bridge bridge_checker u_chk (.*);

// File: tb/tcp_stream_bridge_tb.sv
`timescale 1ns/1ps
module tcp_stream_bridge_tb;
  import tcp_bridge_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, engBusy, regWrEn, rxRdEn, dataInValid, dataOutValid, txWrEn;
  logic [3:0]  regAddr;
  logic [31:0] regWrData;
  logic [12:0] rxCount;
  logic [63:0] rxRdData, dataIn, dataOut, txWrData;
  logic        busyHold;
  int          busyCnt = 0;

  tcp_stream_bridge u_dut (.*);

  assign engBusy = busyHold || (busyCnt != 0);

  int checks = 0, fails = 0;
  logic [63:0] rxQ[$];
  logic [63:0] expInQ[$];
  int expLenQ[$];
  int wordNo = 0;
  logic [3:0]  expA[11];
  logic [31:0] expD[11];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pushWords(input int n);
    for (int i = 0; i < n; i++) begin
      logic [63:0] w;
      w = {32'hA5A5_0000 + 32'(wordNo), 32'(wordNo * 7 + 3)};
      wordNo++;
      rxQ.push_back(w);
      expInQ.push_back(w);
    end
    rxCount = 13'(rxQ.size());
  endtask

  task automatic txBurst(input int n);
    expLenQ.push_back(n);
    for (int i = 0; i < n; i++) begin
      dataOutValid = 1'b1;
      dataOut = {32'hC0DE_0000 + 32'(i), 32'(n)};
      step(1);
    end
    dataOutValid = 1'b0;
    step(1);
  endtask

  // engine model: receive buffer and busy after a send command
  always @(posedge clk) begin
    if (rstN && rxRdEn) begin
      checks++;
      if (rxQ.size() == 0) begin
        fails++;
        $display("FAIL R4 read from empty buffer actual=1 expected=0");
      end else begin
        rxRdData <= rxQ.pop_front();
      end
      rxCount <= 13'(rxQ.size());
    end
    if (rstN && regWrEn && regAddr == DEF_CMD_ADDR) busyCnt <= 6;
    else if (busyCnt != 0) busyCnt <= busyCnt - 1;
  end

  // reference monitor, sampled mid-cycle
  int initCnt = 0, lastInitCyc = 0, cyc = 0;
  bit rdEnPrev = 0, busyPrev = 1, validPrev = 0, pendModel = 0, ready = 0, cmdNext = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      rdEnPrev = 0; validPrev = 0; pendModel = 0; ready = 0; cmdNext = 0; busyPrev = 1;
    end else begin
      cyc++;
      chk(!(rxRdEn && !ready), "R3 read before ready", 64'(rxRdEn), 64'd0);
      chk(dataInValid == rdEnPrev, "R5 dataInValid lag", 64'(dataInValid), 64'(rdEnPrev));
      if (dataInValid) begin
        logic [63:0] e;
        e = (expInQ.size() != 0) ? expInQ.pop_front() : 64'hDEAD;
        chk(dataIn == e, "R5 dataIn word", dataIn, e);
      end
      chk(txWrEn == dataOutValid, "R6 txWrEn", 64'(txWrEn), 64'(dataOutValid));
      if (dataOutValid) chk(txWrData == dataOut, "R6 txWrData", txWrData, dataOut);
      chk(!(rxRdEn && !rdEnPrev && pendModel), "R10 read started during commit", 64'(rxRdEn), 64'd0);
      if (cmdNext && !regWrEn) chk(1'b0, "R7 command write missing", 64'd0, 64'd1);
      if (regWrEn) begin
        if (initCnt < 11) begin
          chk(regAddr == expA[initCnt], "R2 setup addr", 64'(regAddr), 64'(expA[initCnt]));
          chk(regWrData == expD[initCnt], "R2 setup data", 64'(regWrData), 64'(expD[initCnt]));
          if (initCnt > 0) chk(cyc == lastInitCyc + 1, "R2 setup consecutive", 64'(cyc), 64'(lastInitCyc + 1));
          lastInitCyc = cyc;
          initCnt++;
        end else if (!cmdNext) begin
          int e;
          e = (expLenQ.size() != 0) ? expLenQ.pop_front() : -1;
          chk(regAddr == DEF_LEN_ADDR, "R7 length addr", 64'(regAddr), 64'(DEF_LEN_ADDR));
          chk(regWrData == 32'(e), "R9 length value", 64'(regWrData), 64'(e));
          chk(!busyPrev, "R8 length while busy", 64'(busyPrev), 64'd0);
          pendModel = 0;
          cmdNext = 1;
        end else begin
          chk(regAddr == DEF_CMD_ADDR && regWrData == 0, "R7 command write",
              {28'd0, regAddr, regWrData}, {28'd0, DEF_CMD_ADDR, 32'd0});
          cmdNext = 0;
        end
      end
      if (validPrev && !dataOutValid) pendModel = 1;
      if (initCnt == 11 && !engBusy) ready = 1;
      rdEnPrev = rxRdEn;
      busyPrev = engBusy;
      validPrev = dataOutValid;
    end
  end

  initial begin
    repeat (20000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    expA = '{4'h0, 4'hE, 4'hC, 4'h9, 4'h7, 4'h6, 4'h5, 4'h4, 4'h3, 4'h2, 4'h0};
    expD = '{32'h1, 32'h0, 32'h0, 32'h6000, 32'hEA60, 32'hEA61,
             32'hC0A80750, 32'hC0A80751, 32'h1122, 32'h33445566, 32'h0};
    rstN = 0; busyHold = 1; dataOutValid = 0; dataOut = '0; rxCount = '0; rxRdData = '0;
    step(4);
    chk(!regWrEn, "R1 regWrEn in reset", 64'(regWrEn), 64'd0);
    chk(!rxRdEn, "R1 rxRdEn in reset", 64'(rxRdEn), 64'd0);
    chk(!dataInValid, "R1 dataInValid in reset", 64'(dataInValid), 64'd0);
    chk(!txWrEn, "R1 txWrEn in reset", 64'(txWrEn), 64'd0);
    rstN = 1;
    pushWords(3);
    while (initCnt < 11) step(1);
    step(8);
    chk(rxCount == 3, "R3 words held until ready", 64'(rxCount), 64'd3);
    busyHold = 0;
    step(20);
    chk(rxCount == 0, "R4 drain of 3", 64'(rxCount), 64'd0);
    chk(expInQ.size() == 0, "R5 all words delivered", 64'(expInQ.size()), 64'd0);
    pushWords(8); step(3); pushWords(2); step(30);
    chk(rxCount == 0, "R4 drain with refill", 64'(rxCount), 64'd0);
    chk(expInQ.size() == 0, "R5 refill delivered", 64'(expInQ.size()), 64'd0);
    pushWords(1); step(10);
    chk(rxCount == 0, "R4 single word", 64'(rxCount), 64'd0);
    txBurst(5); step(30);
    chk(expLenQ.size() == 0, "R7 commit of 5", 64'(expLenQ.size()), 64'd0);
    txBurst(1); step(30);
    chk(expLenQ.size() == 0, "R7 commit of 1", 64'(expLenQ.size()), 64'd0);
    busyHold = 1;
    txBurst(4);
    pushWords(3);
    step(20);
    chk(rxCount == 3, "R10 no read while commit pending", 64'(rxCount), 64'd3);
    chk(expLenQ.size() == 1, "R8 length held while busy", 64'(expLenQ.size()), 64'd1);
    busyHold = 0;
    step(40);
    chk(expLenQ.size() == 0, "R8 length after busy drops", 64'(expLenQ.size()), 64'd0);
    chk(rxCount == 0, "R10 reads resume after commit", 64'(rxCount), 64'd0);
    txBurst(2); txBurst(6); step(40);
    chk(expLenQ.size() == 0, "R9 back-to-back lengths", 64'(expLenQ.size()), 64'd0);
    chk(expInQ.size() == 0, "R4 nothing left behind", 64'(expInQ.size()), 64'd0);
    step(5);
    report();
    $finish;
  end
endmodule